// File: doc/BRIEF.md
# Configurable Interrupt Trigger Detector

This block watches a bank of synchronous interrupt request lines and keeps one pending bit for each. Each line has three configuration bits: a sensitivity bit that picks level or edge behaviour, a polarity bit, and a both-edges bit. Together they make the line trigger on a high level, a low level, a rising edge, a falling edge or any edge. The configuration can be changed at run time. The block samples every line on every clock and stores the level it saw, which it uses for edge detection on the next cycle.

For a level line, the pending bit follows the active condition one cycle later and never latches. For an edge line, a detected edge sets the pending bit, and the bit then holds until a bit in the clear mask removes it. The pending vector goes to the register and routing logic that sits downstream. That logic holds the configuration and combines the pending bits into processor requests.

Top module: `irq_trigger_detect`

## Requirements
- R1: With sensitivity 1 and polarity 1 (active-high level), the pending bit after a clock edge equals the line value sampled at that edge.
- R2: With sensitivity 1 and polarity 0 (active-low level), the pending bit after a clock edge equals the inverse of the line value sampled at that edge.
- R3: With sensitivity 0, both-edges 0 and polarity 1, a sample of 1 that follows a stored level of 0 sets the pending bit.
- R4: With sensitivity 0, both-edges 0 and polarity 0, a sample of 0 that follows a stored level of 1 sets the pending bit.
- R5: With sensitivity 0 and both-edges 1, any sample that differs from the stored level sets the pending bit.
- R6: An edge-mode pending bit stays set while no clear mask bit is applied. A clear mask bit of 1 on a cycle with no new edge drops it on the next clock.
- R7: The clear mask has no effect on a line with sensitivity 1.
- R8: When a new edge and a clear mask bit arrive for the same edge-mode line in the same cycle, the pending bit is set after the clock.
- R9: The stored level of every line takes the sampled value on every clock, whatever the configuration. Switching a line from level to edge mode while its input is steady therefore detects no edge.
- R10: Reset (rst_n low, asynchronous) forces all pending bits and all stored levels to 0. A line that is high on the first clock after reset, configured for rising edges, becomes pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Synchronous interrupt lines, sampled every clock |
| cfg_level_i | input | NUM_SRC | 1 = level-sensitive, 0 = edge-sensitive |
| cfg_high_i | input | NUM_SRC | Polarity: 1 = high level / rising edge, 0 = low level / falling edge |
| cfg_both_i | input | NUM_SRC | 1 = edge line triggers on either edge (ignored for level lines) |
| clr_i | input | NUM_SRC | Per-line clear of latched edge events |
| pending_o | output | NUM_SRC | Raw pending vector |

## Verification
The 51 lines are spread over all five trigger modes, and the mode assignment rotates several times. Pseudo-random line values and a sparse random clear mask then exercise every combination of stored level, new sample and clear on every mode. This separates the modes from one another and catches a pending bit that latches when it should follow, or that follows when it should latch. Directed sequences on one line cover the remaining cases, each of which a wrong design could otherwise hide: an edge and a clear in the same cycle, a clear sent to a level line, a switch from level to edge mode with the input held steady, and the first sample after reset.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

   // Per-line trigger configuration
   typedef struct packed {
      logic level;   // 1: level-sensitive, 0: edge-sensitive
      logic high;    // polarity select
      logic both;    // any-edge select (edge mode only)
   } trig_cfg_t;

   localparam int MAX_SRC = 64;

endpackage

// File: rtl/trig_event_decode.sv
module trig_event_decode
   import irq_trig_pkg::*;
(
   input  trig_cfg_t cfg_i,
   input  logic      prev_i,
   input  logic      cur_i,
   output logic      edge_hit_o,
   output logic      lvl_active_o
);

   logic rise;
   logic fall;

   always_comb begin
      rise = ~prev_i & cur_i;
      fall = prev_i & ~cur_i;
      if (cfg_i.both)
         edge_hit_o = rise | fall;
      else if (cfg_i.high)
         edge_hit_o = rise;
      else
         edge_hit_o = fall;
      lvl_active_o = cfg_i.high ? cur_i : ~cur_i;
   end

endmodule

// File: rtl/trig_cell.sv
module trig_cell
   import irq_trig_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      src_i,
   input  trig_cfg_t cfg_i,
   input  logic      clr_i,
   output logic      pending_o
);

   logic prev_q;
   logic pend_q;
   logic edge_hit;
   logic lvl_active;

   trig_event_decode u_dec (
      .cfg_i        (cfg_i),
      .prev_i       (prev_q),
      .cur_i        (src_i),
      .edge_hit_o   (edge_hit),
      .lvl_active_o (lvl_active)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= src_i;
         if (cfg_i.level)
            pend_q <= lvl_active;
         else
            pend_q <= edge_hit | (pend_q & ~clr_i);
      end
   end

   assign pending_o = pend_q;

   AST_LVL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.level && cfg_i.high) |=> (pend_q == $past(src_i)));          // R1
   AST_LVL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.level && !cfg_i.high) |=> (pend_q == !$past(src_i)));        // R2
   AST_RISE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_i.level && !cfg_i.both && cfg_i.high && !prev_q && src_i) |=> pend_q); // R3
   AST_FALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_i.level && !cfg_i.both && !cfg_i.high && prev_q && !src_i) |=> pend_q); // R4
   AST_DUAL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_i.level && cfg_i.both && (prev_q != src_i)) |=> pend_q);       // R5
   AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_i.level && pend_q && !clr_i) |=> pend_q);                      // R6
   AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_i.level && clr_i && !edge_hit) |=> !pend_q);                   // R6
   AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_i.level && edge_hit) |=> pend_q);                              // R8
   AST_PREV_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (prev_q == $past(src_i)));                                  // R9
   AST_RST_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (!pend_q && !prev_q));                                    // R10

endmodule

// File: rtl/irq_trigger_detect.sv
module irq_trigger_detect
   import irq_trig_pkg::*;
#(
   parameter int NUM_SRC = 51
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [NUM_SRC-1:0] cfg_level_i,
   input  logic [NUM_SRC-1:0] cfg_high_i,
   input  logic [NUM_SRC-1:0] cfg_both_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pending_o
);

   localparam int LAST = NUM_SRC - 1;

   generate
      if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_width
         $error("irq_trigger_detect: NUM_SRC out of range");
      end
   endgenerate

   generate
      for (genvar i = 0; i <= LAST; i++) begin : g_src
         trig_cfg_t cfg;
         assign cfg = '{level: cfg_level_i[i], high: cfg_high_i[i], both: cfg_both_i[i]};

         trig_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (src_i[i]),
            .cfg_i     (cfg),
            .clr_i     (clr_i[i]),
            .pending_o (pending_o[i])
         );
      end
   endgenerate

   AST_LVL_CLR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pending_o & $past(cfg_level_i))
                == ($past(cfg_level_i) & ~($past(src_i) ^ $past(cfg_high_i))))); // R7

endmodule

// File: tb/tb_irq_trigger_detect.sv
module tb_irq_trigger_detect;
   localparam int N = 51;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst_n;
   logic [N-1:0] src, lvl, high, both, clr;
   logic [N-1:0] pending;
   logic [N-1:0] m_prev, m_pend;
   logic [63:0]  rng;
   int errs = 0;
   int checks = 0;

   irq_trigger_detect #(.NUM_SRC(N)) dut (
      .clk(clk), .rst_n(rst_n), .src_i(src), .cfg_level_i(lvl),
      .cfg_high_i(high), .cfg_both_i(both), .clr_i(clr), .pending_o(pending)
   );

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   function automatic string tag_of(int i);
      if (lvl[i]) return high[i] ? "R1" : "R2";
      if (both[i]) return "R5";
      return high[i] ? "R3" : "R4";
   endfunction

   // mode 0 high level, 1 low level, 2 rising, 3 falling, 4 any edge
   task automatic set_modes(int k);
      for (int i = 0; i < N; i++) begin
         int m = (i + k) % 5;
         lvl[i]  = (m < 2);
         high[i] = (m == 0) || (m == 2);
         both[i] = (m == 4);
      end
   endtask

   function automatic logic [63:0] next_rng(logic [63:0] x);
      logic [63:0] y = x;
      y = y ^ (y << 13);
      y = y ^ (y >> 7);
      y = y ^ (y << 17);
      return y;
   endfunction

   // apply current inputs for one clock, compare whole vector to the model
   task automatic step();
      logic [N-1:0] nx;
      for (int i = 0; i < N; i++) begin
         logic hit;
         if (lvl[i]) nx[i] = high[i] ? src[i] : ~src[i];
         else begin
            if (both[i]) hit = m_prev[i] ^ src[i];
            else if (high[i]) hit = ~m_prev[i] & src[i];
            else hit = m_prev[i] & ~src[i];
            nx[i] = hit | (m_pend[i] & ~clr[i]);
         end
      end
      @(posedge clk); #1;
      m_prev = src;
      m_pend = nx;
      for (int i = 0; i < N; i++) chk(tag_of(i), pending[i], m_pend[i]);
   endtask

   initial begin
      #2000000;
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      set_modes(2);           // line 0 rising edge
      src = '1; clr = '0;
      rng = 64'h9E3779B97F4A7C15;
      repeat (2) @(posedge clk);
      #1;
      for (int i = 0; i < N; i++) chk("R10 reset", pending[i], 1'b0);
      m_prev = '0; m_pend = '0;
      rst_n = 1'b1;
      step();
      chk("R10 first rise", pending[0], 1'b1);
      step(); step();
      chk("R6 hold", pending[0], 1'b1);
      clr[0] = 1'b1; step(); clr[0] = 1'b0;
      chk("R6 clear", pending[0], 1'b0);
      step();
      chk("R6 stays clear", pending[0], 1'b0);
      src[0] = 1'b0; step();
      src[0] = 1'b1; clr[0] = 1'b1; step(); clr[0] = 1'b0;
      chk("R8 edge beats clear", pending[0], 1'b1);
      // line 0 active-high level
      lvl[0] = 1'b1; high[0] = 1'b1; both[0] = 1'b0;
      src[0] = 1'b1; clr[0] = 1'b1; step();
      chk("R7 clear on level", pending[0], 1'b1);
      step(); clr[0] = 1'b0;
      chk("R7 clear on level", pending[0], 1'b1);
      src[0] = 1'b0; step();
      src[0] = 1'b1; step();
      // switch to rising edge with input steady high and clear the old level
      lvl[0] = 1'b0; clr[0] = 1'b1; step(); clr[0] = 1'b0;
      chk("R9 no edge after mode switch", pending[0], 1'b0);
      // sweep: rotating modes, random lines, sparse clears
      for (int cyc = 0; cyc < 1000; cyc++) begin
         if (cyc % 100 == 0) set_modes(cyc / 100);
         rng = next_rng(rng);
         src = rng[N-1:0];
         rng = next_rng(rng);
         clr = rng[N-1:0];
         rng = next_rng(rng);
         clr = clr & rng[N-1:0];
         step();
      end
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule